// File: doc/BRIEF.md
# Line-Rate Oscillator Band Selector

This block watches the horizontal sync pulse of an incoming video signal using a fixed reference clock. From the measured line period and the programmed horizontal resolution factor (`horr`), it works out the pixel clock the display PLL must produce, which is line rate × `horr` × 12. It then picks one of four oscillator frequency bands for that clock. The band boundaries sit at 28 MHz, 56 MHz and 112 MHz of pixel clock, and the top band reaches 150 MHz.

The line period is counted in reference cycles between rising sync edges. The sum of four consecutive periods forms one band decision. The band output only moves when two decisions in a row agree, which keeps a line rate that sits on a boundary from making the oscillator hop between bands.

When sync edges stop arriving, the block drops its sync-present flag. A low flag asks the clocking logic to switch to the slow internal oscillator of about 2.5 MHz. While sync is absent, the band code keeps its last value.

Top module: `vco_band_sel`

## Requirements
- R1: After a synchronous reset, `band` is 0, `sync_ok` is 0 and `band_valid` is 0.
- R2: `hsync` passes through a two-flop synchronizer. The third rising clock edge after `hsync` is first sampled high processes the rising edge, and from that cycle on `sync_ok` is 1.
- R3: If `TIMEOUT` (65536) reference cycles pass after the last processed rising edge with no new one, `sync_ok` falls to 0 and `band` keeps its value. A period of exactly `TIMEOUT` cycles is still accepted.
- R4: The first edge after reset, enable or sync loss only starts the timing. Each band decision then uses the sum S of the next four line periods. With steady lines, the first `band_valid` therefore follows the ninth edge and never the eighth.
- R5: With X = `REF_MHZ` × `horr` × 48, a decision is code 0 when X < 28·S, code 1 when 28·S ≤ X < 56·S, code 2 when 56·S ≤ X < 112·S, and code 3 otherwise. An exact boundary falls into the upper band.
- R6: `band` is loaded with a decision only when that decision equals the immediately preceding one. Each such confirmation pulses `band_valid` high for one cycle, two clock edges after the closing edge is processed. Decisions that alternate never move `band`.
- R7: A sync loss empties the partial sum and the decision history, so two fresh decisions are needed before `band` can change again.
- R8: While `enable` is 0, edges are ignored, `sync_ok` stays 0, `band_valid` stays 0, `band` holds its value, and the measurement and decision history are cleared.
- R9: `horr` is sampled when a decision is made, so a new `horr` with unchanged lines leads to a new band after two decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (`REF_MHZ` MHz) |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Measurement enable |
| hsync | input | 1 | Horizontal sync pulse, asynchronous, active edge rising |
| horr | input | 8 | Horizontal resolution factor |
| band | output | 2 | Oscillator band code, 0 lowest to 3 highest |
| sync_ok | output | 1 | Sync present; low requests the internal fallback clock |
| band_valid | output | 1 | One-cycle strobe on each confirmed band decision |

## Verification
The bench goes after the exact boundary of 28 MHz (lines of 300 versus 301 cycles at `horr` = 14). A design with a strict compare there, or one that rounds, would report band 0 where band 1 is due.

It also feeds decision windows that alternate across the 56 MHz boundary. A design without the two-in-a-row rule would toggle `band` and strobe `band_valid` on every window. Counting `band_valid` pulses after eight and after nine lines catches an averager that counts the first edge as a period or decides too early.

A silence longer than the timeout checks the fallback: a design that cleared `band`, or kept its old history, would show a wrong band or an early strobe when sync returns. The enable-low stretch with live lines checks that nothing leaks through while the block is disabled.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

    typedef logic [1:0] band_t;

    typedef struct packed {
        logic  vld;
        band_t code;
    } vote_t;

    localparam int unsigned EDGE_LO_MHZ  = 28;
    localparam int unsigned EDGE_MID_MHZ = 56;
    localparam int unsigned EDGE_HI_MHZ  = 112;
    localparam int unsigned PIX_PER_CHAR = 12;
    localparam int unsigned LINES_AVG    = 4;

    // num = ref_MHz * horr * 12 * 4 ; sum = four line periods in ref cycles
    function automatic band_t classify(input logic [31:0] num, input logic [31:0] sum);
        band_t b;
        if (num >= EDGE_HI_MHZ * sum)       b = 2'd3;
        else if (num >= EDGE_MID_MHZ * sum) b = 2'd2;
        else if (num >= EDGE_LO_MHZ * sum)  b = 2'd1;
        else                                b = 2'd0;
        return b;
    endfunction

endpackage

// File: rtl/vbs_edge_sync.sv
module vbs_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/vbs_period_meter.sv
module vbs_period_meter #(
    parameter int TIMEOUT = 65536,
    parameter int CW      = $clog2(TIMEOUT + 1),
    parameter int SW      = CW + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          rise,
    output logic          sum_vld,
    output logic [SW-1:0] sum,
    output logic          sync_ok,
    output logic          restart
);
    logic [CW-1:0] cnt;
    logic [SW-1:0] acc;
    logic [1:0]    nper;
    logic [SW-1:0] acc_next;

    assign acc_next = acc + SW'(cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            acc     <= '0;
            nper    <= '0;
            sum     <= '0;
            sum_vld <= 1'b0;
            sync_ok <= 1'b0;
            restart <= 1'b0;
        end else begin
            sum_vld <= 1'b0;
            restart <= 1'b0;
            if (!en) begin
                cnt     <= '0;
                acc     <= '0;
                nper    <= '0;
                sync_ok <= 1'b0;
            end else if (rise) begin
                cnt     <= CW'(1);
                sync_ok <= 1'b1;
                if (sync_ok) begin
                    if (nper == 2'(vbs_pkg::LINES_AVG - 1)) begin
                        sum     <= acc_next;
                        sum_vld <= 1'b1;
                        acc     <= '0;
                        nper    <= '0;
                    end else begin
                        acc  <= acc_next;
                        nper <= nper + 2'd1;
                    end
                end
            end else if (cnt == CW'(TIMEOUT)) begin
                if (sync_ok) restart <= 1'b1;
                sync_ok <= 1'b0;
                acc     <= '0;
                nper    <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    AST_LOSS_CLEARS_SYNC: assert property (@(posedge clk) disable iff (rst)
        restart |-> !sync_ok); // R3
    AST_SYNC_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_ok) |-> $past(rise)); // R2
    AST_SUM_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        sum_vld |-> (sum >= SW'(4) && sum <= SW'(4 * TIMEOUT))); // R4
    AST_OFF_NO_SYNC: assert property (@(posedge clk) disable iff (rst)
        !en |=> !sync_ok); // R8
endmodule

// File: rtl/vbs_band_vote.sv
module vbs_band_vote #(
    parameter int REF_MHZ = 50,
    parameter int SW      = 19
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          restart,
    input  logic          sum_vld,
    input  logic [SW-1:0] sum,
    input  logic [7:0]    horr,
    output vbs_pkg::band_t band,
    output logic          band_valid
);
    import vbs_pkg::*;

    localparam int unsigned SCALE = PIX_PER_CHAR * LINES_AVG;

    vote_t       hist;
    band_t       dec;
    logic [31:0] num;

    assign num = 32'(REF_MHZ) * 32'(horr) * 32'(SCALE);
    assign dec = classify(num, 32'(sum));

    always_ff @(posedge clk) begin
        if (rst) begin
            band       <= '0;
            band_valid <= 1'b0;
            hist       <= '0;
        end else begin
            band_valid <= 1'b0;
            if (!en || restart) begin
                hist.vld <= 1'b0;
            end else if (sum_vld) begin
                if (hist.vld && hist.code == dec) begin
                    band       <= dec;
                    band_valid <= 1'b1;
                end
                hist <= '{vld: 1'b1, code: dec};
            end
        end
    end

    AST_BAND_MOVES_ON_VOTE: assert property (@(posedge clk) disable iff (rst)
        (band != $past(band)) |-> band_valid); // R6
    AST_QUIET_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!en || restart) |=> !band_valid); // R7
    AST_HOLD_ON_LOSS: assert property (@(posedge clk) disable iff (rst)
        restart |=> $stable(band)); // R3
endmodule

// File: rtl/vco_band_sel.sv
module vco_band_sel #(
    parameter int REF_MHZ = 50,
    parameter int TIMEOUT = 65536
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       hsync,
    input  logic [7:0] horr,
    output logic [1:0] band,
    output logic       sync_ok,
    output logic       band_valid
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam int SW = CW + 2;

    logic          rise;
    logic          sum_vld;
    logic [SW-1:0] sum;
    logic          restart;

    vbs_edge_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (hsync),
        .rise (rise)
    );

    vbs_period_meter #(.TIMEOUT(TIMEOUT), .CW(CW), .SW(SW)) u_meter (
        .clk     (clk),
        .rst     (rst),
        .en      (enable),
        .rise    (rise),
        .sum_vld (sum_vld),
        .sum     (sum),
        .sync_ok (sync_ok),
        .restart (restart)
    );

    vbs_band_vote #(.REF_MHZ(REF_MHZ), .SW(SW)) u_vote (
        .clk        (clk),
        .rst        (rst),
        .en         (enable),
        .restart    (restart),
        .sum_vld    (sum_vld),
        .sum        (sum),
        .horr       (horr),
        .band       (band),
        .band_valid (band_valid)
    );
endmodule

// File: tb/sim_vco_band_sel.sv
module sim_vco_band_sel;
    localparam int REF_MHZ = 50;
    localparam int TMO     = 65536;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       hsync = 1'b0;
    logic [7:0] horr = 8'd40;
    logic [1:0] band;
    logic       sync_ok;
    logic       band_valid;

    integer checks = 0;
    integer errs = 0;
    integer bv_cnt = 0;

    always #2 clk = ~clk;

    vco_band_sel #(.REF_MHZ(REF_MHZ), .TIMEOUT(TMO)) u0 (
        .clk(clk), .rst(rst), .enable(enable), .hsync(hsync), .horr(horr),
        .band(band), .sync_ok(sync_ok), .band_valid(band_valid)
    );

    // behavioural reference model
    integer q_hs[$];
    integer m_since, m_sum4, m_nlines, m_sok, m_pend, m_pend_sum, m_lost;
    integer m_prev, m_band, m_bv;
    integer px, d, r;

    function automatic integer pick_band(input integer h, input integer s);
        integer x;
        x = REF_MHZ * h * 48;
        if (x < 28 * s) return 0;
        if (x < 56 * s) return 1;
        if (x < 112 * s) return 2;
        return 3;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            q_hs = '{0, 0, 0};
            m_since = 0; m_sum4 = 0; m_nlines = 0; m_sok = 0;
            m_pend = 0; m_pend_sum = 0; m_lost = 0;
            m_prev = -1; m_band = 0; m_bv = 0;
        end else begin
            // decision stage, one cycle behind the measurement
            m_bv = 0;
            if (!enable || m_lost) m_prev = -1;
            else if (m_pend) begin
                d = pick_band(horr, m_pend_sum);
                if (m_prev == d) begin m_band = d; m_bv = 1; end
                m_prev = d;
            end
            m_pend = 0; m_lost = 0;
            // measurement stage
            r = (q_hs[1] == 1 && q_hs[2] == 0);
            if (!enable) begin
                m_since = 0; m_sum4 = 0; m_nlines = 0; m_sok = 0;
            end else if (r) begin
                if (m_sok) begin
                    m_sum4 += m_since; m_nlines++;
                    if (m_nlines == 4) begin
                        m_pend = 1; m_pend_sum = m_sum4; m_sum4 = 0; m_nlines = 0;
                    end
                end
                m_since = 1; m_sok = 1;
            end else if (m_since == TMO) begin
                if (m_sok) m_lost = 1;
                m_sok = 0; m_sum4 = 0; m_nlines = 0;
            end else m_since++;
            q_hs.push_front(int'(hsync));
            px = q_hs.pop_back();
        end
    end

    task automatic chk(input string tag, input integer act, input integer exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("R5 band vs model", band, m_band);
            chk("R2 sync_ok vs model", sync_ok, m_sok);
            chk("R6 band_valid vs model", band_valid, m_bv);
            if (band_valid) bv_cnt++;
        end
    end

    task automatic send_line(input integer p);
        hsync = 1'b1;
        repeat (p / 2) @(negedge clk);
        hsync = 1'b0;
        repeat (p - p / 2) @(negedge clk);
    endtask

    task automatic send_lines(input integer n, input integer p);
        for (int i = 0; i < n; i++) send_line(p);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 reset band", band, 0);
        chk("R1 reset sync_ok", sync_ok, 0);
        chk("R1 reset band_valid", band_valid, 0);
        rst = 1'b0;
        enable = 1'b1;
        repeat (4) @(negedge clk);

        // R4: 24 MHz lines, first strobe only after the ninth edge
        horr = 8'd40;
        bv_cnt = 0;
        send_lines(8, 1000);
        chk("R4 no strobe after eight edges", bv_cnt, 0);
        chk("R2 sync present", sync_ok, 1);
        send_line(1000);
        chk("R4 strobe after ninth edge", bv_cnt, 1);
        chk("R5 band for 24 MHz", band, 0);

        send_lines(13, 400);
        chk("R5 band for 60 MHz", band, 2);
        send_lines(13, 200);
        chk("R5 band for 120 MHz", band, 3);
        send_lines(13, 600);
        chk("R5 band for 40 MHz", band, 1);

        // R5 boundary at 28 MHz with horr 14
        horr = 8'd14;
        send_lines(13, 301);
        chk("R5 just below 28 MHz", band, 0);
        send_lines(13, 300);
        chk("R5 exactly 28 MHz", band, 1);

        // R9: new horr with same lines
        horr = 8'd28;
        send_lines(13, 300);
        chk("R9 horr change to 56 MHz", band, 2);

        // R6: alternating decisions across 56 MHz never move band
        enable = 1'b0;
        repeat (4) @(negedge clk);
        enable = 1'b1;
        repeat (4) @(negedge clk);
        bv_cnt = 0;
        for (int k = 0; k < 2; k++) begin
            send_lines(4, 301);
            send_lines(4, 300);
        end
        send_line(300);
        chk("R6 alternating decisions no strobe", bv_cnt, 0);
        chk("R6 band held on alternation", band, 2);

        // R8: disabled block ignores lines
        enable = 1'b0;
        horr = 8'd40;
        bv_cnt = 0;
        send_lines(5, 1000);
        chk("R8 sync_ok low when disabled", sync_ok, 0);
        chk("R8 no strobe when disabled", bv_cnt, 0);
        chk("R8 band held when disabled", band, 2);
        enable = 1'b1;
        repeat (4) @(negedge clk);

        // R3: loss of sync after timeout, band held
        send_lines(10, 200);
        chk("R5 band for 120 MHz again", band, 3);
        send_line(10);
        repeat (65520) @(negedge clk);
        chk("R3 sync still present before timeout", sync_ok, 1);
        repeat (30) @(negedge clk);
        chk("R3 sync dropped after timeout", sync_ok, 0);
        chk("R3 band held after loss", band, 3);

        // R7: fresh history after loss
        bv_cnt = 0;
        send_lines(8, 1000);
        chk("R7 no early strobe after loss", bv_cnt, 0);
        chk("R7 band unchanged before two decisions", band, 3);
        send_line(1000);
        chk("R7 strobe after two fresh decisions", bv_cnt, 1);
        chk("R7 band after reacquire", band, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule